// File: doc/BRIEF.md
# Capability List Builder

This block appends capability entries to a device's configuration space and keeps them chained as a singly linked list. Each request carries a one-byte capability identifier and a payload length. The payload then arrives one byte per cycle over a valid/ready stream. The block picks a dword-aligned slot for the new entry. It checks that the entry fits below a fixed ceiling and then issues plain byte writes to the configuration store. Those writes patch the link byte of the previous entry, or the list head pointer for the first entry. They then fill the identifier, a zero link byte and the payload.

These writes carry no write mask, so read-only bits in the store are overwritten as well. A rejected request writes nothing. After the first entry is added, a level output reports that capabilities are present; it feeds the status register. When the added identifier is the MSI-X one, the block records the dword index of its slot so that later writes to its message-control field can be watched.

A one-cycle completion pulse ends every request. It returns either the assigned byte offset or an error code.

Top module: `cap_list_builder`

## Requirements
- R1: After reset the first accepted entry is placed at offset 0x40, and the byte at offset 0x34 (list head pointer) is written with 0x40.
- R2: Each later entry is placed at (previous offset + previous length + 3) with the two low bits cleared, and the byte at previous offset + 1 (the previous entry's link byte) is written with the new offset.
- R3: A request whose slot offset plus length exceeds 192 completes with error code 2 and zero byte writes. It leaves the list state unchanged, so the next entry that fits is placed where it would have been placed anyway.
- R4: A request with length 0 completes with error code 1 and zero byte writes.
- R5: An accepted entry produces exactly length + 3 byte writes, in this order:
  - the link byte;
  - the identifier at the slot offset;
  - 0x00 at slot + 1;
  - payload byte i at slot + 2 + i.
  All eight data bits are written as given, with no mask.
- R6: `caps_present` is 0 after reset. It becomes 1 in the cycle after the first successful completion and then stays 1 until reset.
- R7: When an entry with identifier 0x11 completes successfully, `msix_vld` is 1 and `msix_idx` equals the slot offset divided by 4, starting in the cycle after the completion.
- R8: `req_ready` is high only while the block is idle. `pay_ready` is high only during the payload phase. A payload byte is consumed only in a cycle where both `pay_valid` and `pay_ready` are high, so idle gaps in the stream are tolerated.
- R9: `done` is a single-cycle pulse with `done_err` 0 = success, 1 = empty, 2 = full. `done_offset` carries the slot on success and 0 on error.
- R10: Reset empties the list, so the next entry again goes to offset 0x40 and uses the head pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New entry request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_id | input | 8 | Capability identifier |
| req_len | input | LEN_W | Payload length in bytes |
| pay_valid | input | 1 | Payload byte valid |
| pay_ready | output | 1 | Payload byte accepted |
| pay_data | input | 8 | Payload byte |
| wr_en | output | 1 | Configuration byte write strobe |
| wr_addr | output | ADDR_W | Configuration byte address |
| wr_data | output | 8 | Configuration byte data |
| done | output | 1 | Completion pulse |
| done_err | output | 2 | 0 success, 1 empty, 2 full |
| done_offset | output | ADDR_W | Assigned slot offset (0 on error) |
| caps_present | output | 1 | Capabilities-present status bit |
| msix_vld | output | 1 | An MSI-X entry has been placed |
| msix_idx | output | ADDR_W-2 | Dword index of the MSI-X entry |

## Verification
The checker module verifies several properties on every cycle:
- `done` is a single-cycle pulse that never coincides with a write;
- an error completion carries a zero offset;
- every successful offset is dword aligned and at least 0x40;
- the request and payload handshakes are never both open;
- `caps_present` never falls;
- `msix_vld` only rises right after a successful completion.

Other behaviour depends on which request came before, so only the bench scenarios can show it. That covers the exact slot arithmetic across a chain of entries, the patching of the previous link byte, and the exact-ceiling and one-past-ceiling cases. It also covers the absence of writes on a reject and the return to offset 0x40 after reset.

// File: rtl/cap_list_pkg.sv
// Package: shared codes for the capability list builder.
// Assumes: error codes are visible at the top ports as a 2-bit field.
package cap_list_pkg;

    typedef enum logic [1:0] {
        CL_OK    = 2'd0,
        CL_EMPTY = 2'd1,
        CL_FULL  = 2'd2
    } cl_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REJECT,
        S_LINK,
        S_ID,
        S_NXT,
        S_PAY,
        S_FIN
    } cl_state_e;

endpackage

// File: rtl/cap_slot_alloc.sv
// Module: cap_slot_alloc
// Keeps the list tail (offset and length of the last entry) and the
// capabilities-present and MSI-X records. Offers the next candidate slot,
// the link byte to patch and whether an entry of len_i bytes fits.
// Assumes: CEIL < 2**ADDR_W, and commit_i only for entries that fit.
module cap_slot_alloc #(
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 8,
    parameter int FIRST_OFF = 'h40,
    parameter int HEAD_OFF  = 'h34,
    parameter int CEIL      = 192,
    parameter int MSIX_ID   = 'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] cand_off_o,
    output logic [ADDR_W-1:0] tail_o,
    output logic              fits_o,
    input  logic              commit_i,
    input  logic [7:0]        commit_id_i,
    input  logic [ADDR_W-1:0] commit_off_i,
    input  logic [LEN_W-1:0]  commit_len_i,
    output logic              caps_present_o,
    output logic              msix_vld_o,
    output logic [ADDR_W-3:0] msix_idx_o
);
    localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;

    logic              have_q;
    logic [ADDR_W-1:0] last_off_q;
    logic [LEN_W-1:0]  last_len_q;
    logic [SUM_W-1:0]  end_rnd;
    logic [SUM_W-1:0]  cand_w;
    logic [SUM_W-1:0]  entry_end;

    // Slot and fit arithmetic for the entry being requested.
    always_comb begin
        end_rnd    = SUM_W'(last_off_q) + SUM_W'(last_len_q) + SUM_W'(3);
        cand_w     = have_q ? (end_rnd & ~SUM_W'(3)) : SUM_W'(FIRST_OFF);
        entry_end  = cand_w + SUM_W'(len_i);
        fits_o     = (entry_end <= SUM_W'(CEIL));
        cand_off_o = cand_w[ADDR_W-1:0];
        tail_o     = have_q ? (last_off_q + ADDR_W'(1)) : ADDR_W'(HEAD_OFF);
    end

    // List tail and status records, updated on each committed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q         <= 1'b0;
            last_off_q     <= '0;
            last_len_q     <= '0;
            caps_present_o <= 1'b0;
            msix_vld_o     <= 1'b0;
            msix_idx_o     <= '0;
        end else if (commit_i) begin
            have_q         <= 1'b1;
            last_off_q     <= commit_off_i;
            last_len_q     <= commit_len_i;
            caps_present_o <= 1'b1;
            if (commit_id_i == 8'(MSIX_ID)) begin
                msix_vld_o <= 1'b1;
                msix_idx_o <= commit_off_i[ADDR_W-1:2];
            end
        end
    end

endmodule

// File: rtl/cap_write_seq.sv
// Module: cap_write_seq
// Request and payload sequencer. Accepts a request when idle, rejects
// empty or oversized entries without writing, otherwise emits the link,
// identifier, zero link and payload byte writes, then pulses done.
// Assumes: the slot inputs are valid in the same cycle as the request.
module cap_write_seq
    import cap_list_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_id,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [7:0]        pay_data,
    input  logic [ADDR_W-1:0] cand_off_i,
    input  logic [ADDR_W-1:0] tail_i,
    input  logic              fits_i,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic [1:0]        done_err,
    output logic [ADDR_W-1:0] done_offset,
    output logic              commit_o,
    output logic [7:0]        commit_id_o,
    output logic [ADDR_W-1:0] commit_off_o,
    output logic [LEN_W-1:0]  commit_len_o
);
    cl_state_e         state_q;
    cl_err_e           err_q;
    logic [7:0]        id_q;
    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] slot_q;
    logic [ADDR_W-1:0] tail_q;
    logic [LEN_W-1:0]  cnt_q;

    // State and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            err_q   <= CL_OK;
            id_q    <= '0;
            len_q   <= '0;
            slot_q  <= '0;
            tail_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (req_valid) begin
                    id_q   <= req_id;
                    len_q  <= req_len;
                    slot_q <= cand_off_i;
                    tail_q <= tail_i;
                    cnt_q  <= '0;
                    if (req_len == '0) begin
                        err_q   <= CL_EMPTY;
                        state_q <= S_REJECT;
                    end else if (!fits_i) begin
                        err_q   <= CL_FULL;
                        state_q <= S_REJECT;
                    end else begin
                        err_q   <= CL_OK;
                        state_q <= S_LINK;
                    end
                end
                S_REJECT: state_q <= S_IDLE;
                S_LINK:   state_q <= S_ID;
                S_ID:     state_q <= S_NXT;
                S_NXT:    state_q <= S_PAY;
                S_PAY: if (pay_valid) begin
                    cnt_q <= cnt_q + LEN_W'(1);
                    if (cnt_q == len_q - LEN_W'(1)) state_q <= S_FIN;
                end
                S_FIN:    state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    // Byte write port driven from the current phase.
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        case (state_q)
            S_LINK: begin wr_en = 1'b1; wr_addr = tail_q; wr_data = 8'(slot_q); end
            S_ID:   begin wr_en = 1'b1; wr_addr = slot_q; wr_data = id_q; end
            S_NXT:  begin wr_en = 1'b1; wr_addr = slot_q + ADDR_W'(1); wr_data = 8'h00; end
            S_PAY:  begin
                wr_en   = pay_valid;
                wr_addr = slot_q + ADDR_W'(2) + ADDR_W'(cnt_q);
                wr_data = pay_data;
            end
            default: ;
        endcase
    end

    // Handshake, completion and commit outputs.
    always_comb begin
        req_ready    = (state_q == S_IDLE);
        pay_ready    = (state_q == S_PAY);
        done         = (state_q == S_REJECT) || (state_q == S_FIN);
        done_err     = (state_q == S_REJECT) ? err_q : CL_OK;
        done_offset  = (state_q == S_FIN) ? slot_q : '0;
        commit_o     = (state_q == S_FIN);
        commit_id_o  = id_q;
        commit_off_o = slot_q;
        commit_len_o = len_q;
    end

endmodule

// File: rtl/cap_list_builder.sv
// Module: cap_list_builder (top)
// Appends capability entries to configuration space as a linked list
// through an unmasked byte write port.
// Assumes: the configuration store applies every wr_en byte as given.
module cap_list_builder #(
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 8,
    parameter int FIRST_OFF = 'h40,
    parameter int HEAD_OFF  = 'h34,
    parameter int CEIL      = 192,
    parameter int MSIX_ID   = 'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_id,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [7:0]        pay_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic [1:0]        done_err,
    output logic [ADDR_W-1:0] done_offset,
    output logic              caps_present,
    output logic              msix_vld,
    output logic [ADDR_W-3:0] msix_idx
);
    logic [ADDR_W-1:0] cand_off;
    logic [ADDR_W-1:0] tail_off;
    logic              fits;
    logic              commit;
    logic [7:0]        commit_id;
    logic [ADDR_W-1:0] commit_off;
    logic [LEN_W-1:0]  commit_len;

    cap_slot_alloc #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIRST_OFF(FIRST_OFF),
        .HEAD_OFF(HEAD_OFF), .CEIL(CEIL), .MSIX_ID(MSIX_ID)
    ) alloc_i (
        .clk(clk), .rst_n(rst_n), .len_i(req_len),
        .cand_off_o(cand_off), .tail_o(tail_off), .fits_o(fits),
        .commit_i(commit), .commit_id_i(commit_id),
        .commit_off_i(commit_off), .commit_len_i(commit_len),
        .caps_present_o(caps_present), .msix_vld_o(msix_vld),
        .msix_idx_o(msix_idx)
    );

    cap_write_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_len(req_len),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .cand_off_i(cand_off), .tail_i(tail_off), .fits_i(fits),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .done_err(done_err), .done_offset(done_offset),
        .commit_o(commit), .commit_id_o(commit_id),
        .commit_off_o(commit_off), .commit_len_o(commit_len)
    );

endmodule

// File: rtl/cap_list_builder_chk.sv
// Module: cap_list_builder_chk
// Port-level properties of the capability list builder, bound to the top.
// Assumes: default-sized parameters are passed by the bind.
module cap_list_builder_chk #(
    parameter int ADDR_W    = 8,
    parameter int FIRST_OFF = 'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              pay_ready,
    input logic              wr_en,
    input logic              done,
    input logic [1:0]        done_err,
    input logic [ADDR_W-1:0] done_offset,
    input logic              caps_present,
    input logic              msix_vld
);
    // R9: completion lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: error completions carry a zero offset
    assert_err_zero_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err != 2'd0) |-> (done_offset == '0));

    // R2: successful offsets are dword aligned and not below the first slot
    assert_slot_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err == 2'd0) |-> (done_offset[1:0] == 2'b00 && done_offset >= ADDR_W'(FIRST_OFF)));

    // R3: no byte write in a completion cycle
    assert_no_write_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    // R8: request and payload handshakes never open together
    assert_hs_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && pay_ready));

    // R8: writes only while busy
    assert_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !req_ready);

    // R6: the status bit never falls outside reset
    assert_caps_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        caps_present |=> caps_present);

    // R7: the MSI-X record only appears after a successful completion
    assert_msix_after_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msix_vld) |-> $past(done && done_err == 2'd0));

endmodule

bind cap_list_builder cap_list_builder_chk #(.ADDR_W(ADDR_W), .FIRST_OFF(FIRST_OFF)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .pay_ready(pay_ready),
    .wr_en(wr_en), .done(done), .done_err(done_err), .done_offset(done_offset),
    .caps_present(caps_present), .msix_vld(msix_vld)
);

// File: tb/cap_list_builder_tb_top.sv
module cap_list_builder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [7:0] req_id = '0;
    logic [7:0] req_len = '0;
    logic       pay_valid = 1'b0;
    logic       pay_ready;
    logic [7:0] pay_data = '0;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       done;
    logic [1:0] done_err;
    logic [7:0] done_offset;
    logic       caps_present;
    logic       msix_vld;
    logic [5:0] msix_idx;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    logic [7:0] mem [0:255];
    logic       have_prev = 1'b0;
    logic [7:0] prev_off = '0;

    always #2.5 clk = ~clk;

    cap_list_builder dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_len(req_len), .pay_valid(pay_valid),
        .pay_ready(pay_ready), .pay_data(pay_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .done_err(done_err),
        .done_offset(done_offset), .caps_present(caps_present),
        .msix_vld(msix_vld), .msix_idx(msix_idx)
    );

    // Configuration store model fed by the byte write port.
    always @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // Vector: [31:24] id, [23:16] length, [15:8] expected error, [7:0] expected offset
    localparam logic [31:0] VECS [0:6] = '{
        32'h01_06_00_40,   // first entry (R1)
        32'h11_0A_00_48,   // MSI-X entry, chained (R2, R7)
        32'h05_00_01_00,   // empty (R4)
        32'h09_64_00_54,   // long entry ends at 184 (R2)
        32'h10_09_02_00,   // would end at 193 (R3)
        32'h10_08_00_B8,   // ends exactly at 192 (R3)
        32'h03_01_02_00    // one past the ceiling (R3)
    };

    function automatic logic [7:0] pat(input logic [7:0] id, input int i);
        return id ^ (8'(i) * 8'h1d + 8'h5a);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [7:0] id, input int len, input logic [1:0] eerr,
                          input logic [7:0] eoff);
        int i = 0;
        int cyc = 0;
        int wstart;
        bit got = 0;
        bit acc;
        logic [1:0] gerr = '0;
        logic [7:0] goff = '0;
        logic [7:0] tail;
        bit okall = 1;
        tail = have_prev ? prev_off + 8'd1 : 8'h34;
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_len = 8'(len);
        wstart = wr_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        if (eerr == 2'd0) check(req_ready == 1'b0, "R8 req_ready low while busy", int'(req_ready), 0);
        while (!got && cyc < 1000) begin
            if (done) begin
                got = 1; gerr = done_err; goff = done_offset;
            end else begin
                pay_valid = (cyc % 3 != 2) && (i < len);
                pay_data  = pat(id, i);
                #1;
                acc = pay_valid && pay_ready;
                @(posedge clk);
                if (acc) i++;
                @(negedge clk);
                pay_valid = 1'b0;
                cyc++;
            end
        end
        check(got, "R9 done seen", int'(got), 1);
        check(gerr == eerr, "R9 done_err", int'(gerr), int'(eerr));
        check(goff == eoff, "R9 done_offset", int'(goff), int'(eoff));
        if (eerr == 2'd0) begin
            check(mem[tail] == eoff, have_prev ? "R2 previous link patched" : "R1 head pointer",
                  int'(mem[tail]), int'(eoff));
            check(mem[eoff] == id, "R5 identifier byte", int'(mem[eoff]), int'(id));
            check(mem[eoff + 8'd1] == 8'h00, "R5 zero link byte", int'(mem[eoff + 8'd1]), 0);
            for (int k = 0; k < len; k++)
                if (mem[8'(eoff + 8'd2 + 8'(k))] != pat(id, k)) okall = 0;
            check(okall, "R5 payload bytes", int'(okall), 1);
            check(wr_cnt - wstart == len + 3, "R5 write count", wr_cnt - wstart, len + 3);
            @(negedge clk);
            check(caps_present == 1'b1, "R6 caps_present set", int'(caps_present), 1);
            if (id == 8'h11) begin
                check(msix_vld == 1'b1, "R7 msix_vld", int'(msix_vld), 1);
                check(msix_idx == 6'(eoff >> 2), "R7 msix_idx", int'(msix_idx), int'(eoff >> 2));
            end
            have_prev = 1'b1;
            prev_off  = eoff;
        end else begin
            check(wr_cnt - wstart == 0, eerr == 2'd1 ? "R4 no writes" : "R3 no writes",
                  wr_cnt - wstart, 0);
            @(negedge clk);
            check(done == 1'b0, "R9 single pulse", int'(done), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'hEE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(caps_present == 1'b0, "R6 caps_present after reset", int'(caps_present), 0);
        check(msix_vld == 1'b0, "R7 msix_vld after reset", int'(msix_vld), 0);
        check(req_ready == 1'b1, "R8 req_ready idle", int'(req_ready), 1);
        check(pay_ready == 1'b0, "R8 pay_ready idle", int'(pay_ready), 0);
        check(done == 1'b0, "R9 done after reset", int'(done), 0);

        for (int v = 0; v < 7; v++)
            do_req(VECS[v][31:24], int'(VECS[v][23:16]), VECS[v][9:8], VECS[v][7:0]);

        // R10: reset empties the list
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(caps_present == 1'b0, "R10 caps_present cleared", int'(caps_present), 0);
        check(msix_vld == 1'b0, "R10 msix_vld cleared", int'(msix_vld), 0);
        have_prev = 1'b0;
        do_req(8'h11, 4, 2'd0, 8'h40);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule